// File: doc/BRIEF.md
# Row Zero-Bias Correction Engine

This block receives an image sensor frame as a stream of unsigned 8-bit pixels and keeps it in an internal frame buffer. A pixel value of 0 means the cell saw no light and 255 means the cell saw full light. Each sensor row carries 64 image pixels followed by 2 pixels from columns that are painted over. Those two covered pixels should read zero. Any value they carry is the offset error for that row. When a row has been stored, the engine takes the mean of the two covered values as the row bias. It then makes a second pass over the stored row and subtracts the bias from each image pixel.

A host starts a capture with a one-cycle start strobe. The host then waits for the done flag and reads the corrected 64x64 frame through a read port. The read port returns data one cycle after each read strobe. A five-state controller sequences the work: idle, row fetch, bias computation, bias removal, and row advance. The frame buffer has one port for the engine and one port for the host, so it maps onto a dual-port block RAM.

Top module: `rzb_engine`

## Requirements
- R1: After a synchronous reset, `done`, `pix_ready` and `host_rvalid` are all low.
- R2: A `start` pulse while idle begins a capture. On the next cycle `pix_ready` is high and `done` is low.
- R3: Each row takes exactly 66 accepted pixels. Accepted pixels 0 to 63 are image columns 0 to 63. Accepted pixels 64 and 65 are covered reference values and are never stored in the frame buffer.
- R4: The row bias is the 9-bit sum of the two reference pixels shifted right by one, with the fraction dropped. For example, 12 and 14 give 13, and 0 and 1 give 0.
- R5: A stored pixel is the image pixel minus the row bias. A result that would fall below 0 is stored as 0.
- R6: A pixel is taken only on a cycle where `pix_valid` and `pix_ready` are both high. Idle gaps in `pix_valid` do not change the stored frame.
- R7: After row 63 is corrected, the engine returns to idle. At that point `done` goes high and `pix_ready` stays low.
- R8: A host read strobe returns `host_rdata` on the following cycle, with `host_rvalid` high for exactly that one cycle. The address is row*64 + column.
- R9: A `start` pulse during a capture is ignored. The capture in progress continues unchanged.
- R10: `done` stays high until the next accepted `start`. Each row's bias depends only on that row's own reference pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture launch strobe |
| pix_valid | input | 1 | Sensor pixel present |
| pix_data | input | 8 | Sensor pixel value |
| pix_ready | output | 1 | Engine accepts a pixel this cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host read address, {row, column} |
| host_rdata | output | 8 | Corrected pixel read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| done | output | 1 | Frame corrected and ready |

## Verification
The bench targets the following corner cases:
- Bias truncation. It uses a row whose reference sum is odd. A design that rounds the bias up would leave every pixel in that row one lower.
- Saturation. It uses a row where the bias exceeds most of the pixels. A design without a floor would wrap those pixels to large values near 255.
- Stream stalls. Random gaps in `pix_valid` catch a design that counts cycles instead of handshakes, because its columns would shift.
- Start during a capture. A start pulse in the middle of a frame catches a design that restarts, because its rows would move and `done` would arrive late or never.
- Reference columns. Reading back every address catches a design that stores the reference pixels or skips the last column.

// File: rtl/rzb_pkg.sv
package rzb_pkg;
  localparam int REF_COLS = 2;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GETROW,
    ST_BIAS,
    ST_FIX,
    ST_NEXT
  } rzb_state_e;
endpackage

// File: rtl/rzb_frame_mem.sv
module rzb_frame_mem #(
  parameter int DW = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // engine port: write, or read with a one-cycle registered result
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // host port: read only
  always_ff @(posedge clk) begin
    if (b_rd) b_rdata <= mem[b_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) b_rvalid <= 1'b0;
    else     b_rvalid <= b_rd;
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    b_rd |=> b_rvalid); // R8
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    !b_rd |=> !b_rvalid); // R8
endmodule

// File: rtl/rzb_bias_unit.sv
module rzb_bias_unit #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref0_we,
  input  logic          ref1_we,
  input  logic [PW-1:0] ref_data,
  input  logic          bias_load,
  input  logic [PW-1:0] raw_pix,
  output logic [PW-1:0] fixed_pix
);
  logic [PW-1:0] ref0_q, ref1_q, bias_q;
  logic [PW:0]   ref_sum;

  assign ref_sum = {1'b0, ref0_q} + {1'b0, ref1_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ref0_q <= '0;
      ref1_q <= '0;
      bias_q <= '0;
    end else begin
      if (ref0_we)   ref0_q <= ref_data;
      if (ref1_we)   ref1_q <= ref_data;
      if (bias_load) bias_q <= ref_sum[PW:1];
    end
  end

  // saturating subtract, floor at zero
  always_comb begin
    if (raw_pix > bias_q) fixed_pix = raw_pix - bias_q;
    else                  fixed_pix = '0;
  end

  AST_BIAS_BETWEEN_REFS: assert property (@(posedge clk) disable iff (rst)
    bias_load |=> (bias_q >= ((ref0_q < ref1_q) ? ref0_q : ref1_q)) &&
                  (bias_q <= ((ref0_q < ref1_q) ? ref1_q : ref0_q))); // R4
  AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    fixed_pix <= raw_pix); // R5
endmodule

// File: rtl/rzb_ctrl.sv
module rzb_ctrl
  import rzb_pkg::*;
#(
  parameter int PW   = 8,
  parameter int ROWS = 64,
  parameter int COLS = 64
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  start,
  input  logic                                  pix_valid,
  input  logic [PW-1:0]                         pix_data,
  output logic                                  pix_ready,
  input  logic [PW-1:0]                         fixed_pix,
  output logic                                  mem_we,
  output logic [$clog2(ROWS)+$clog2(COLS)-1:0]  mem_addr,
  output logic [PW-1:0]                         mem_wdata,
  output logic                                  ref0_we,
  output logic                                  ref1_we,
  output logic                                  bias_load,
  output logic                                  done
);
  localparam int RW      = $clog2(ROWS);
  localparam int CW      = $clog2(COLS);
  localparam int ROW_LEN = COLS + REF_COLS;
  localparam int KW      = $clog2(ROW_LEN + 1);

  rzb_state_e    state_q;
  logic [RW-1:0] row_q;
  logic [KW-1:0] col_q;
  logic          phase_q;
  logic          done_q;
  logic          accept;

  assign pix_ready = (state_q == ST_GETROW);
  assign accept    = pix_ready && pix_valid;
  assign done      = done_q;

  assign mem_addr  = {row_q, col_q[CW-1:0]};
  assign mem_we    = (accept && (col_q < KW'(COLS))) || (state_q == ST_FIX && phase_q);
  assign mem_wdata = (state_q == ST_FIX) ? fixed_pix : pix_data;
  assign ref0_we   = accept && (col_q == KW'(COLS));
  assign ref1_we   = accept && (col_q == KW'(COLS + 1));
  assign bias_load = (state_q == ST_BIAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          row_q   <= '0;
          col_q   <= '0;
          phase_q <= 1'b0;
          if (start) begin
            done_q  <= 1'b0;
            state_q <= ST_GETROW;
          end
        end
        ST_GETROW: begin
          if (accept) begin
            if (col_q == KW'(ROW_LEN - 1)) begin
              col_q   <= '0;
              state_q <= ST_BIAS;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
        end
        ST_BIAS: begin
          phase_q <= 1'b0;
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          // phase 0 reads the pixel, phase 1 writes it back corrected
          phase_q <= ~phase_q;
          if (phase_q) begin
            if (col_q == KW'(COLS - 1)) state_q <= ST_NEXT;
            else                        col_q   <= col_q + 1'b1;
          end
        end
        ST_NEXT: begin
          col_q <= '0;
          if (row_q == RW'(ROWS - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= ST_GETROW;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && state_q == ST_IDLE) |=> (!done && pix_ready)); // R2
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GETROW) |-> (col_q < KW'(ROW_LEN))); // R3
  AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GETROW && !pix_valid) |=> ($stable(col_q) && state_q == ST_GETROW)); // R6
  AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> !done); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R10
  AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start && state_q == ST_GETROW && !pix_valid) |=> $stable(row_q)); // R9
endmodule

// File: rtl/rzb_engine.sv
module rzb_engine #(
  parameter int PW   = 8,
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int AW   = $clog2(ROWS) + $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_data,
  output logic          pix_ready,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  output logic [PW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          done
);
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;
  logic [PW-1:0] mem_rdata;
  logic [PW-1:0] fixed_pix;
  logic          ref0_we, ref1_we, bias_load;

  rzb_ctrl #(.PW(PW), .ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_ready (pix_ready),
    .fixed_pix (fixed_pix),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ref0_we   (ref0_we),
    .ref1_we   (ref1_we),
    .bias_load (bias_load),
    .done      (done)
  );

  rzb_bias_unit #(.PW(PW)) u_bias (
    .clk       (clk),
    .rst       (rst),
    .ref0_we   (ref0_we),
    .ref1_we   (ref1_we),
    .ref_data  (pix_data),
    .bias_load (bias_load),
    .raw_pix   (mem_rdata),
    .fixed_pix (fixed_pix)
  );

  rzb_frame_mem #(.DW(PW), .AW(AW)) u_mem (
    .clk      (clk),
    .rst      (rst),
    .a_we     (mem_we),
    .a_addr   (mem_addr),
    .a_wdata  (mem_wdata),
    .a_rdata  (mem_rdata),
    .b_rd     (host_rd),
    .b_addr   (host_addr),
    .b_rdata  (host_rdata),
    .b_rvalid (host_rvalid)
  );
endmodule

// File: tb/tb_rzb_engine.sv
module tb_rzb_engine;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int LEN  = COLS + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        pix_ready;
  logic        host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] img [ROWS][LEN];

  always #10 clk = ~clk; // 50 MHz

  rzb_engine dut (
    .clk(clk), .rst(rst), .start(start), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .host_rd(host_rd),
    .host_addr(host_addr), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .done(done)
  );

  function automatic logic [7:0] exp_pix(logic [7:0] p, logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    logic [7:0] bias;
    s = {1'b0, a} + {1'b0, b};
    bias = s[8:1];
    return (p > bias) ? p - bias : 8'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send(logic [7:0] v);
    logic rdy;
    forever begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        pix_valid = 1'b0;                 // R6 stall cycle
        pix_data  = 8'($urandom);
        continue;
      end
      pix_valid = 1'b1;
      pix_data  = v;
      rdy = pix_ready;
      @(posedge clk);
      if (rdy) break;
    end
  endtask

  task automatic send_frame(bit busy_start);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < LEN; c++) send(img[r][c]);
      @(negedge clk) pix_valid = 1'b0;
      if (busy_start && r == 5) pulse_start(); // R9: ignored mid-frame
    end
    @(negedge clk) pix_valid = 1'b0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(req, done, 1);
    check("R7 ready low when done", pix_ready, 0);
  endtask

  task automatic read_frame(string tag);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic [7:0] e;
        string req;
        e = exp_pix(img[r][c], img[r][COLS], img[r][COLS+1]);
        if (r == 0 || r == 2 || r == 3) req = {tag, " R4"};
        else if (r == 1)                req = {tag, " R5"};
        else                            req = {tag, " R3 R6 R10"};
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = 12'(r * COLS + c);
        @(negedge clk);
        host_rd = 1'b0;
        check("R8 rvalid", host_rvalid, 1);
        check(req, host_rdata, e);
      end
    end
    @(negedge clk);
    check("R8 rvalid single pulse", host_rvalid, 0);
  endtask

  task automatic build_frame(int seed_off);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LEN; c++) begin
        if (c < COLS) img[r][c] = 8'($urandom);
        else          img[r][c] = 8'($urandom_range(0, 20 + seed_off));
      end
    img[0][COLS] = 8'd12; img[0][COLS+1] = 8'd14;        // R4 bias 13
    img[0][0] = 8'd13; img[0][1] = 8'd14; img[0][2] = 8'd12;
    img[1][COLS] = 8'd255; img[1][COLS+1] = 8'd255;      // R5 floor at 0
    img[1][0] = 8'd0; img[1][1] = 8'd255; img[1][2] = 8'd254;
    img[2][COLS] = 8'd0; img[2][COLS+1] = 8'd1;          // R4 truncation
    img[2][0] = 8'd0; img[2][1] = 8'd1;
    img[3][COLS] = 8'd3; img[3][COLS+1] = 8'd4;          // R4 bias 3
    img[3][COLS-1] = 8'd3;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 pix_ready", pix_ready, 0);
    check("R1 host_rvalid", host_rvalid, 0);

    // frame 1
    build_frame(0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 ready after start", pix_ready, 1);
    check("R2 done low", done, 0);
    send_frame(1'b0);
    wait_done("R7 done after frame");
    read_frame("F1");
    repeat (5) @(negedge clk);
    check("R10 done held", done, 1);

    // frame 2, with a start pulse while busy
    build_frame(200);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 done cleared by start", done, 0);
    check("R2 ready", pix_ready, 1);
    send_frame(1'b1);
    wait_done("R9 done after busy start");
    read_frame("F2 R9");
    finish_run();
  end
endmodule